// File: doc/BRIEF.md
# Link Frame Word Encoder

This block turns frame requests into a stream of 32-bit link words, one word per clock, for an 8b/10b serialiser. Each word comes with a 4-bit control-character mask, one bit per byte. Bit i of the mask belongs to byte i, and bit 0 is the least significant byte. When no frame is in progress the block sends a fixed idle word. When a request is accepted it emits, in order, a start delimiter, two header words, the body for the frame kind, a CRC word and an end delimiter. After the end delimiter it keeps a short idle gap before it can accept the next request.

Four frame kinds exist, selected by `req_kind`: 0 is init, 1 is command, 2 is data and 3 is acknowledge. Command and data frames take their payload from a buffer read port. The block drives the word address and a read strobe, and the buffer returns a 64-bit word in the same cycle. A data frame sends each 64-bit word as two cycles, low half first. A command frame sends only the low 32 bits of each buffer word. The 8b/10b coding and the serial transceiver are outside this block.

The state machine has these states. S_IDLE sends idle and accepts requests. S_SOF sends the start delimiter. S_HSEQ and S_HLEN send the header. S_DESC_LO and S_DESC_HI send the descriptor or status. S_PAY_LO and S_PAY_HI send the payload. S_CRC sends the checksum. S_EOF sends the end delimiter. S_GAP sends idle while the gap runs out.

The transitions are:
- S_IDLE→S_SOF when a request is accepted.
- S_SOF→S_HSEQ→S_HLEN.
- S_HLEN→S_CRC for init frames; S_HLEN→S_DESC_LO for all other kinds.
- S_DESC_LO→S_DESC_HI for data and acknowledge frames.
- S_DESC_LO→S_PAY_LO, or →S_CRC when the length is zero, for command frames.
- S_DESC_HI→S_CRC for acknowledge frames.
- S_DESC_HI→S_PAY_LO, or →S_CRC when the length is zero, for data frames.
- S_PAY_LO→S_PAY_HI for data frames.
- S_PAY_LO→S_PAY_LO, or →S_CRC on the last word, for command frames.
- S_PAY_HI→S_PAY_LO, or →S_CRC on the last word.
- S_CRC→S_EOF.
- S_EOF→S_GAP, or →S_IDLE when the gap needs no extra cycle.
- S_GAP→S_IDLE when the gap has run out.

Top module: `link_frame_encoder`

## Requirements
- R1: While no frame is in progress, including during reset, the output word is 0x7CBCDC1C with mask 4'b1111.
- R2: The word after an accepted request is 0x000000FB with mask 4'b0001.
- R3: The first header word is {kind==3, req_seq[30:0]}, so bit 31 is 1 only for acknowledge frames.
- R4: The second header word carries req_link in bits 31:16 and the length in bits 15:0. The length is forced to 0 for init and acknowledge frames.
- R5: A command frame sends {req_write, req_desc[30:0]}, then rd_data[31:0] for buffer addresses 0 up to length-1, one word per cycle.
- R6: A data frame sends req_desc low half then high half. It then sends each buffer word at addresses 0 up to length-1 as rd_data[31:0] followed by rd_data[63:32].
- R7: An acknowledge frame sends req_desc low half then high half as its status, and it never asserts rd_en.
- R8: After the body come the CRC word and then 0x0000FD00 with mask 4'b0010. The CRC uses polynomial 0x04C11DB7, starts from all ones, takes each word's bit 31 first, and is not inverted at the end. It covers the first header word through the last body word.
- R9: Every word between the start delimiter and the end delimiter has mask 4'b0000.
- R10: Exactly IDLE_GAP idle words (2 by default) separate back-to-back frames. req_ready is high only in the accepting idle state.
- R11: rd_en is high only in the cycles that send a payload word's low half, and rd_addr then equals that word's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Frame request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_kind | input | 2 | Frame kind: 0 init, 1 command, 2 data, 3 acknowledge |
| req_seq | input | 31 | Sequence number |
| req_link | input | 16 | Link identifier |
| req_len | input | 16 | Payload word count |
| req_write | input | 1 | Write flag for command frames |
| req_desc | input | 64 | Data descriptor, command code or acknowledge status |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | ADDR_W | Buffer word address |
| rd_data | input | 64 | Buffer word, valid in the cycle of rd_en |
| tx_word | output | 32 | Link word |
| tx_k | output | 4 | Control-character mask, bit i for byte i |

## Verification
Two events can fall in the same cycle: the end of one frame's idle gap and the acceptance of the next request. The bench provokes this by queueing several requests at once, so req_valid stays high through the end delimiter and the gap. The model then predicts acceptance exactly in the first cycle where req_ready may rise. The bench compares every output word, mask, req_ready and read strobe against that model, so one idle word too many or too few between frames is reported.

// File: rtl/lfe_pkg.sv
package lfe_pkg;

    typedef enum logic [1:0] {
        FK_INIT = 2'd0,
        FK_CMD  = 2'd1,
        FK_DATA = 2'd2,
        FK_ACK  = 2'd3
    } frame_kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_SOF, S_HSEQ, S_HLEN, S_DESC_LO, S_DESC_HI,
        S_PAY_LO, S_PAY_HI, S_CRC, S_EOF, S_GAP
    } enc_state_e;

    localparam logic [31:0] IDLE_WORD = 32'h7CBC_DC1C;
    localparam logic [3:0]  IDLE_K    = 4'b1111;
    localparam logic [31:0] SOF_WORD  = 32'h0000_00FB;
    localparam logic [3:0]  SOF_K     = 4'b0001;
    localparam logic [31:0] EOF_WORD  = 32'h0000_FD00;
    localparam logic [3:0]  EOF_K     = 4'b0010;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

    // One 32-bit word folded into the running CRC, bit 31 first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [31:0] din);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 31; i >= 0; i--) begin
            fb = c[31] ^ din[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/lfe_crc_acc.sv
module lfe_crc_acc
    import lfe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [31:0] din,
    output logic [31:0] crc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc <= CRC_SEED;
        else if (clear) crc <= CRC_SEED;
        else if (en)    crc <= crc32_step(crc, din);
    end
endmodule

// File: rtl/lfe_word_counter.sv
module lfe_word_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] idx,
    output logic         last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     idx <= '0;
        else if (clear) idx <= '0;
        else if (inc)   idx <= idx + 1'b1;
    end

    assign last = (idx == limit - 1'b1);
endmodule

// File: rtl/link_frame_encoder.sv
module link_frame_encoder
    import lfe_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int LEN_W    = 16,
    parameter int IDLE_GAP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [30:0]       req_seq,
    input  logic [15:0]       req_link,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    input  logic [63:0]       req_desc,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [63:0]       rd_data,
    output logic [31:0]       tx_word,
    output logic [3:0]        tx_k
);
    localparam int GAP_CYC = IDLE_GAP - 1;
    localparam int GW      = $clog2(IDLE_GAP + 1);

    enc_state_e        state_q, state_d;
    frame_kind_e       kind_q;
    logic [30:0]       seq_q;
    logic [15:0]       link_q;
    logic [LEN_W-1:0]  len_q;
    logic              write_q;
    logic [63:0]       desc_q;
    logic [31:0]       hi_q;
    logic [GW-1:0]     gap_q;
    logic [31:0]       crc_q;
    logic [LEN_W-1:0]  idx;
    logic              idx_last;
    logic              accept;
    logic              crc_en;
    logic              idx_inc;
    logic              len_zero;

    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign len_zero  = (len_q == '0);
    assign idx_inc   = (state_q == S_PAY_HI) ||
                       (state_q == S_PAY_LO && kind_q == FK_CMD);
    assign crc_en    = (state_q inside {S_HSEQ, S_HLEN, S_DESC_LO,
                                        S_DESC_HI, S_PAY_LO, S_PAY_HI});

    lfe_crc_acc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == S_SOF),
        .en    (crc_en),
        .din   (tx_word),
        .crc   (crc_q)
    );

    lfe_word_counter #(.W(LEN_W)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == S_SOF),
        .inc   (idx_inc),
        .limit (len_q),
        .idx   (idx),
        .last  (idx_last)
    );

    // State register and captured request fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= FK_INIT;
            seq_q   <= '0;
            link_q  <= '0;
            len_q   <= '0;
            write_q <= 1'b0;
            desc_q  <= '0;
            hi_q    <= '0;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q  <= frame_kind_e'(req_kind);
                seq_q   <= req_seq;
                link_q  <= req_link;
                len_q   <= (req_kind == FK_INIT || req_kind == FK_ACK) ? '0 : req_len;
                write_q <= req_write;
                desc_q  <= req_desc;
            end
            if (state_q == S_PAY_LO) hi_q <= rd_data[63:32];
            gap_q <= (state_q == S_GAP) ? gap_q + 1'b1 : '0;
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid) state_d = S_SOF;
            S_SOF:     state_d = S_HSEQ;
            S_HSEQ:    state_d = S_HLEN;
            S_HLEN:    state_d = (kind_q == FK_INIT) ? S_CRC : S_DESC_LO;
            S_DESC_LO: begin
                if (kind_q == FK_CMD) state_d = len_zero ? S_CRC : S_PAY_LO;
                else                  state_d = S_DESC_HI;
            end
            S_DESC_HI: begin
                if (kind_q == FK_ACK) state_d = S_CRC;
                else                  state_d = len_zero ? S_CRC : S_PAY_LO;
            end
            S_PAY_LO: begin
                if (kind_q == FK_CMD) state_d = idx_last ? S_CRC : S_PAY_LO;
                else                  state_d = S_PAY_HI;
            end
            S_PAY_HI:  state_d = idx_last ? S_CRC : S_PAY_LO;
            S_CRC:     state_d = S_EOF;
            S_EOF:     state_d = (GAP_CYC == 0) ? S_IDLE : S_GAP;
            S_GAP:     if (int'(gap_q) >= GAP_CYC - 1) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Output word, mask and buffer read port
    always_comb begin
        tx_word = IDLE_WORD;
        tx_k    = IDLE_K;
        rd_en   = 1'b0;
        rd_addr = idx[ADDR_W-1:0];
        unique case (state_q)
            S_IDLE, S_GAP: begin
                tx_word = IDLE_WORD;
                tx_k    = IDLE_K;
            end
            S_SOF: begin
                tx_word = SOF_WORD;
                tx_k    = SOF_K;
            end
            S_HSEQ: begin
                tx_word = {kind_q == FK_ACK, seq_q};
                tx_k    = 4'b0000;
            end
            S_HLEN: begin
                tx_word = {link_q, len_q[15:0]};
                tx_k    = 4'b0000;
            end
            S_DESC_LO: begin
                tx_word = (kind_q == FK_CMD) ? {write_q, desc_q[30:0]} : desc_q[31:0];
                tx_k    = 4'b0000;
            end
            S_DESC_HI: begin
                tx_word = desc_q[63:32];
                tx_k    = 4'b0000;
            end
            S_PAY_LO: begin
                tx_word = rd_data[31:0];
                tx_k    = 4'b0000;
                rd_en   = 1'b1;
            end
            S_PAY_HI: begin
                tx_word = hi_q;
                tx_k    = 4'b0000;
            end
            S_CRC: begin
                tx_word = crc_q;
                tx_k    = 4'b0000;
            end
            S_EOF: begin
                tx_word = EOF_WORD;
                tx_k    = EOF_K;
            end
            default: begin
                tx_word = IDLE_WORD;
                tx_k    = IDLE_K;
            end
        endcase
    end

    // R2
    sof_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tx_k == SOF_K && tx_word == SOF_WORD));

    // R3
    seq_ack_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HSEQ) |-> (tx_word[31] == (kind_q == FK_ACK)));

    // R8
    eof_after_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CRC) |=> (tx_k == EOF_K && tx_word == EOF_WORD));

    // R7
    ack_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == FK_ACK && state_q != S_IDLE) |-> !rd_en);

    // R10
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_k == EOF_K) |=> (tx_k == IDLE_K && (IDLE_GAP < 2 || !req_ready)));

    // R11
    data_read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind_q == FK_DATA) |=> !rd_en);

endmodule

// File: tb/link_frame_encoder_tb.sv
module link_frame_encoder_tb;
    localparam int ADDR_W   = 9;
    localparam int IDLE_GAP = 2;

    typedef struct {
        logic [31:0] w;
        logic [3:0]  k;
        logic        rd;
        int          addr;
        int          tag;
    } exp_t;

    typedef struct {
        logic [1:0]  kind;
        logic [30:0] seq;
        logic [15:0] link;
        logic [15:0] len;
        logic        wr;
        logic [63:0] desc;
    } req_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_kind = '0;
    logic [30:0]       req_seq = '0;
    logic [15:0]       req_link = '0;
    logic [15:0]       req_len = '0;
    logic              req_write = 1'b0;
    logic [63:0]       req_desc = '0;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [63:0]       rd_data;
    logic [31:0]       tx_word;
    logic [3:0]        tx_k;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int idle_cnt = IDLE_GAP;
    bit running = 1'b0;
    exp_t expq[$];
    req_t reqq[$];

    always #10 clk = ~clk;

    function automatic logic [63:0] mem_word(input logic [ADDR_W-1:0] a);
        return {8'hDA, 15'h0, a, 8'h5E, 6'h0, a, ~a};
    endfunction

    assign rd_data = mem_word(rd_addr);

    link_frame_encoder #(.ADDR_W(ADDR_W), .IDLE_GAP(IDLE_GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_seq(req_seq), .req_link(req_link),
        .req_len(req_len), .req_write(req_write), .req_desc(req_desc),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_word(tx_word), .tx_k(tx_k)
    );

    // Bytewise CRC model: bit 7 of byte 3 enters first
    function automatic logic [31:0] crc_fold(input logic [31:0] c0, input logic [31:0] d);
        logic [31:0] c;
        c = c0;
        for (int b = 3; b >= 0; b--) begin
            for (int j = 7; j >= 0; j--) begin
                if (c[31] != d[8*b+j]) c = (c << 1) ^ 32'h04C11DB7;
                else                   c = c << 1;
            end
        end
        return c;
    endfunction

    task automatic add(input logic [31:0] w, input logic [3:0] k, input logic rd,
                       input int addr, input int tag);
        exp_t e;
        e.w = w; e.k = k; e.rd = rd; e.addr = addr; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic push_frame(input req_t r);
        logic [31:0] crc;
        logic [31:0] w;
        logic [15:0] ln;
        logic [63:0] m;
        crc = 32'hFFFF_FFFF;
        ln  = (r.kind == 2'd0 || r.kind == 2'd3) ? 16'h0 : r.len;
        add(32'h0000_00FB, 4'b0001, 1'b0, 0, 2);          // R2
        w = {r.kind == 2'd3, r.seq};                       // R3
        add(w, 4'b0000, 1'b0, 0, 3); crc = crc_fold(crc, w);
        w = {r.link, ln};                                  // R4
        add(w, 4'b0000, 1'b0, 0, 4); crc = crc_fold(crc, w);
        if (r.kind == 2'd1) begin                          // R5
            w = {r.wr, r.desc[30:0]};
            add(w, 4'b0000, 1'b0, 0, 5); crc = crc_fold(crc, w);
            for (int i = 0; i < int'(ln); i++) begin
                m = mem_word(ADDR_W'(i));
                add(m[31:0], 4'b0000, 1'b1, i, 5); crc = crc_fold(crc, m[31:0]);
            end
        end else if (r.kind == 2'd2 || r.kind == 2'd3) begin // R6 R7
            add(r.desc[31:0], 4'b0000, 1'b0, 0, (r.kind == 2'd2) ? 6 : 7);
            crc = crc_fold(crc, r.desc[31:0]);
            add(r.desc[63:32], 4'b0000, 1'b0, 0, (r.kind == 2'd2) ? 6 : 7);
            crc = crc_fold(crc, r.desc[63:32]);
            for (int i = 0; i < int'(ln); i++) begin
                m = mem_word(ADDR_W'(i));
                add(m[31:0], 4'b0000, 1'b1, i, 6);  crc = crc_fold(crc, m[31:0]);
                add(m[63:32], 4'b0000, 1'b0, 0, 6); crc = crc_fold(crc, m[63:32]);
            end
        end
        add(crc, 4'b0000, 1'b0, 0, 8);                     // R8
        add(32'h0000_FD00, 4'b0010, 1'b0, 0, 8);
    endtask

    task automatic report_summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Per-cycle model comparison
    always @(negedge clk) begin
        if (running) begin
            exp_t e;
            logic ready_exp;
            cycles++;
            if (cycles > 20000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual %0d cycles expected at most 20000", cycles);
                report_summary();
                $finish;
            end
            ready_exp = (expq.size() == 0) && (idle_cnt >= IDLE_GAP - 1);
            checks++;
            if (req_ready !== ready_exp) begin   // R10
                errors++;
                $display("FAIL R10 ready: actual %b expected %b", req_ready, ready_exp);
            end
            if (expq.size() == 0) begin
                e.w = 32'h7CBC_DC1C; e.k = 4'b1111; e.rd = 1'b0; e.addr = 0; e.tag = 1; // R1
                idle_cnt++;
            end else begin
                e = expq.pop_front();
                idle_cnt = 0;
            end
            checks++;
            if (tx_word !== e.w || tx_k !== e.k) begin
                errors++;
                // R9 is covered here: body words expect mask 0000
                $display("FAIL R%0d word: actual %h/%b expected %h/%b", e.tag, tx_word, tx_k, e.w, e.k);
            end
            checks++;
            if (rd_en !== e.rd || (e.rd && int'(rd_addr) != e.addr)) begin   // R11
                errors++;
                $display("FAIL R11 read: actual %b@%0d expected %b@%0d", rd_en, rd_addr, e.rd, e.addr);
            end
            if (reqq.size() != 0) begin
                req_valid = 1'b1;
                req_kind  = reqq[0].kind;
                req_seq   = reqq[0].seq;
                req_link  = reqq[0].link;
                req_len   = reqq[0].len;
                req_write = reqq[0].wr;
                req_desc  = reqq[0].desc;
            end else begin
                req_valid = 1'b0;
                req_kind  = $urandom_range(3, 0);
                req_len   = 16'hFFFF;
            end
            if (req_valid && req_ready) push_frame(reqq.pop_front());
        end
    end

    task automatic send(input logic [1:0] kind, input logic [30:0] seq, input logic [15:0] link,
                        input logic [15:0] len, input logic wr, input logic [63:0] desc);
        req_t r;
        r.kind = kind; r.seq = seq; r.link = link; r.len = len; r.wr = wr; r.desc = desc;
        reqq.push_back(r);
    endtask

    task automatic drain();
        while (reqq.size() != 0 || expq.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;                                  // R1 during reset
        if (tx_word !== 32'h7CBC_DC1C || tx_k !== 4'b1111) begin
            errors++;
            $display("FAIL R1 reset: actual %h/%b expected 7cbcdc1c/1111", tx_word, tx_k);
        end
        rst_n = 1'b1;
        running = 1'b1;
        repeat (3) @(posedge clk);

        send(2'd0, 31'h0000_0001, 16'h00A1, 16'h0077, 1'b0, 64'h0);      // init, length forced 0 (R4)
        drain();
        send(2'd1, 31'h0000_0002, 16'h00B2, 16'd3, 1'b1, 64'h0_0000_1234); // command write (R5)
        drain();
        send(2'd1, 31'h0000_0003, 16'h00B2, 16'd0, 1'b0, 64'h0_8000_0042); // command read, no payload
        drain();
        send(2'd2, 31'h7FFF_FFFF, 16'h0C33, 16'd4, 1'b0, 64'h1122_3344_5566_7788); // data (R6)
        drain();
        send(2'd2, 31'h0000_0005, 16'h0C33, 16'd0, 1'b0, 64'hCAFE_0000_0000_BEEF); // empty data
        drain();
        send(2'd3, 31'h0000_0006, 16'h0D44, 16'd9, 1'b0, 64'hFEED_FACE_0BAD_F00D); // ack (R7)
        drain();
        // R10: back-to-back requests, acceptance lands as the gap ends
        send(2'd2, 31'h0000_0010, 16'h0001, 16'd2, 1'b0, 64'h0102_0304_0506_0708);
        send(2'd3, 31'h0000_0011, 16'h0002, 16'd0, 1'b0, 64'h0A0B_0C0D_0E0F_1011);
        send(2'd1, 31'h0000_0012, 16'h0003, 16'd5, 1'b0, 64'h0_0000_0099);
        send(2'd0, 31'h0000_0013, 16'h0004, 16'd0, 1'b0, 64'h0);
        drain();

        report_summary();
        $finish;
    end
endmodule